// File: doc/BRIEF.md
# Dual-Channel Timed Serial ADC Batch Collector

This block gathers samples from two external serial converters that only ever send data toward the chip. One shared sampling counter paces both channels. Each time the counter equals a channel's fixed compare value, that channel starts a conversion. It pulls its active-low select line low and waits a programmable number of setup cycles while the converter settles. It then drives sixteen clock pulses and shifts in one sample word, most significant bit first. No transmit line exists. Nothing happens until the counter is enabled.

Each channel has its own small receive FIFO and its own batch buffer of `BATCH_N` words. The FIFO feeds the buffer in arrival order. When channel 0's buffer holds a full batch, a one-cycle completion pulse goes out. Both channels are sampled in step, so this one pulse covers both. A full buffer is frozen so the consumer can read it through the read port. The consumer then pulses the release input. Samples that arrive while a buffer is frozen wait in the FIFO and fill the start of the next batch. A sample that finds its FIFO full is dropped, and that channel's sticky overrun bit is set.

Each channel's conversion engine is a state machine with four states. RX_IDLE has the select high and moves to RX_SETUP on a compare match. RX_SETUP counts the setup cycles down and moves to RX_CLK_LO when the count reaches zero. RX_CLK_LO drives the clock low for one cycle and always moves to RX_CLK_HI. RX_CLK_HI drives the clock high for one cycle and takes in one bit. It returns to RX_CLK_LO while bits remain, and goes back to RX_IDLE after the sixteenth bit. The batch buffer has two states, filling and filled. Writing the last word moves it from filling to filled. A release pulse moves it from filled back to filling.

Top module: `adc_batch_collector`

## Requirements
- R1: During and right after reset, both select lines are high, both clocks are low, the completion pulse is low and both overrun bits are 0.
- R2: While `count_en` is low the counter holds and no select line falls, whatever the other inputs are.
- R3: The counter runs from 0 to `period`-1 and then wraps to 0. While it stays enabled, successive select falls of one channel are exactly `period` clock cycles apart.
- R4: Channel 0 starts when the counter equals 2 and channel 1 when it equals 3. Channel 1's select therefore falls exactly one clock cycle after channel 0's.
- R5: The first clock rising edge comes exactly `setup_cycles`+2 clock cycles after the select falls. After that come 16 pulses, each one cycle low and one cycle high. The select rises when the sixteenth high phase ends.
- R6: A sample is 16 bits, most significant bit first. Each bit is the data line's value at the clock edge that ends that bit's high phase.
- R7: Each channel's buffer stores `BATCH_N` samples in arrival order at indices 0 to `BATCH_N`-1. They are read combinationally on `rd_data`, with `rd_ch` 0 for channel 0 and 1 for channel 1.
- R8: `batch_done` is a one-cycle pulse, given once for each batch that fills channel 0's buffer.
- R9: While a buffer is full and not yet released, up to `FIFO_DEPTH` arriving samples are kept. After release they become the first entries of the next batch, in order, with no overrun.
- R10: A sample that arrives while its channel's FIFO is full is discarded, and that channel's overrun bit goes to 1 and stays there until reset.
- R11: A release pulse has no effect on a buffer that is still filling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Enables the sampling counter |
| period | input | CNT_W | Counter period in clock cycles |
| setup_cycles | input | SETUP_W | Conversion setup wait after select falls |
| adc_miso | input | 2 | Serial data from the converters, bit 0 is channel 0 |
| adc_cs_n | output | 2 | Active-low convert/select per channel |
| adc_sck | output | 2 | Serial clock per channel |
| release_buf | input | 1 | Returns full buffers to filling |
| rd_ch | input | 1 | Channel selected for reading |
| rd_idx | input | IDX_W | Word index for reading |
| rd_data | output | SAMPLE_W | Stored word at the selected channel and index |
| batch_done | output | 1 | One-cycle pulse when channel 0's batch is full |
| overrun | output | 2 | Sticky per-channel sample-loss flags |

## Verification
The hardest situation to reach is a frozen buffer while the FIFO slowly fills. The held samples must then show up at the head of the next batch, and a drop must happen at exactly the sample after the FIFO is full. The stimulus reaches it by waiting after each completion pulse for a chosen number of extra conversions. The counts are below, equal to and above the FIFO depth. The release is always issued just after a new conversion starts, so the number of held samples is known exactly. A mid-batch release, and a pause of the counter with a new period and setup value, are put between batches. Every stored word is then compared against the random words the converter models sent.

// File: rtl/adc_batch_pkg.sv
`timescale 1ns/1ps
package adc_batch_pkg;
    localparam int unsigned SAMPLE_W_DEF = 16;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SETUP,
        RX_CLK_LO,
        RX_CLK_HI
    } rx_state_t;
endpackage

// File: rtl/adc_spi_rx.sv
`timescale 1ns/1ps
module adc_spi_rx import adc_batch_pkg::*; #(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int SETUP_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SETUP_W-1:0]  setup_cycles,
    input  logic                miso,
    output logic                cs_n,
    output logic                sck,
    output logic                word_vld,
    output logic [SAMPLE_W-1:0] word
);
    localparam int BIT_W = $clog2(SAMPLE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SAMPLE_W - 1);

    rx_state_t           state_q, state_d;
    logic [SETUP_W-1:0]  wait_q;
    logic [BIT_W-1:0]    bit_q;
    logic [SAMPLE_W-1:0] shift_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (start) state_d = RX_SETUP;
            RX_SETUP:  if (wait_q == '0) state_d = RX_CLK_LO;
            RX_CLK_LO: state_d = RX_CLK_HI;
            RX_CLK_HI: state_d = (bit_q == LAST_BIT) ? RX_IDLE : RX_CLK_LO;
            default:   state_d = RX_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q   <= '0;
            bit_q    <= '0;
            shift_q  <= '0;
            word     <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (state_q == RX_IDLE && start) begin
                wait_q <= setup_cycles;
                bit_q  <= '0;
            end
            if (state_q == RX_SETUP && wait_q != '0)
                wait_q <= wait_q - 1'b1;
            if (state_q == RX_CLK_HI) begin
                shift_q <= {shift_q[SAMPLE_W-2:0], miso};
                bit_q   <= bit_q + 1'b1;
                if (bit_q == LAST_BIT) begin
                    word     <= {shift_q[SAMPLE_W-2:0], miso};
                    word_vld <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        cs_n = (state_q == RX_IDLE);
        sck  = (state_q == RX_CLK_HI);
    end

    // R5: the select is already released in the cycle the word is handed on
    a_r5_select_up_at_word: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> cs_n);
endmodule

// File: rtl/adc_rx_fifo.sv
`timescale 1ns/1ps
module adc_rx_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          full, accept, take;

    assign full   = (cnt_q == CW'(DEPTH));
    assign empty  = (cnt_q == '0);
    assign accept = push && (!full || pop);
    assign take   = pop && !empty;
    assign dout   = mem[rd_q];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            cnt_q   <= '0;
            overrun <= 1'b0;
        end else begin
            if (accept) wr_q <= wr_q + 1'b1;
            if (take)   rd_q <= rd_q + 1'b1;
            unique case ({accept, take})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (push && !accept) overrun <= 1'b1;
        end
    end

    // R10: once set, the loss flag never clears
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R10: a dropped sample leaves the FIFO full and unchanged in size
    a_r10_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> full);
endmodule

// File: rtl/adc_batch_buf.sv
`timescale 1ns/1ps
module adc_batch_buf #(
    parameter int W = 16,
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_avail,
    input  logic [W-1:0]  in_data,
    output logic          take,
    input  logic          release_buf,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    output logic          filled,
    output logic          fill_done
);
    localparam logic [IW-1:0] LAST_IDX = IW'(N - 1);

    logic [W-1:0]  mem [N];
    logic [IW-1:0] wr_idx;

    assign take    = in_avail && !filled;
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (take) mem[wr_idx] <= in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx    <= '0;
            filled    <= 1'b0;
            fill_done <= 1'b0;
        end else begin
            fill_done <= 1'b0;
            if (take) begin
                if (wr_idx == LAST_IDX) begin
                    wr_idx    <= '0;
                    filled    <= 1'b1;
                    fill_done <= 1'b1;
                end else begin
                    wr_idx <= wr_idx + 1'b1;
                end
            end else if (release_buf && filled) begin
                filled <= 1'b0;
            end
        end
    end

    // R8: the completion indication lasts a single cycle
    a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_done);
    // R11: a release seen while filling leaves the buffer filling
    a_r11_release_ignored_filling: assert property (@(posedge clk) disable iff (!rst_n)
        release_buf && !filled && !take |=> !filled);
endmodule

// File: rtl/adc_batch_collector.sv
`timescale 1ns/1ps
module adc_batch_collector import adc_batch_pkg::*; #(
    parameter int SAMPLE_W   = SAMPLE_W_DEF,
    parameter int CNT_W      = 8,
    parameter int SETUP_W    = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int BATCH_N    = 8,
    parameter int CMP0       = 2,
    parameter int CMP1       = 3,
    localparam int NUM_CH    = 2,
    localparam int IDX_W     = (BATCH_N > 1) ? $clog2(BATCH_N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                count_en,
    input  logic [CNT_W-1:0]    period,
    input  logic [SETUP_W-1:0]  setup_cycles,
    input  logic [NUM_CH-1:0]   adc_miso,
    output logic [NUM_CH-1:0]   adc_cs_n,
    output logic [NUM_CH-1:0]   adc_sck,
    input  logic                release_buf,
    input  logic                rd_ch,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                batch_done,
    output logic [NUM_CH-1:0]   overrun
);
    logic [CNT_W-1:0]    cnt_q;
    logic [SAMPLE_W-1:0] ch_rd [NUM_CH];
    logic [NUM_CH-1:0]   ch_filled;
    logic [NUM_CH-1:0]   ch_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (count_en) begin
            if (cnt_q >= period - 1'b1) cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int CMPV = (g == 0) ? CMP0 : CMP1;
        logic                start, word_vld, fifo_empty, fifo_pop;
        logic [SAMPLE_W-1:0] word, fifo_dout;

        assign start = count_en && (cnt_q == CNT_W'(CMPV));

        adc_spi_rx #(.SAMPLE_W(SAMPLE_W), .SETUP_W(SETUP_W)) u_rx (
            .clk(clk), .rst_n(rst_n), .start(start), .setup_cycles(setup_cycles),
            .miso(adc_miso[g]), .cs_n(adc_cs_n[g]), .sck(adc_sck[g]),
            .word_vld(word_vld), .word(word)
        );

        adc_rx_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(word_vld), .din(word),
            .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty),
            .overrun(overrun[g])
        );

        adc_batch_buf #(.W(SAMPLE_W), .N(BATCH_N)) u_buf (
            .clk(clk), .rst_n(rst_n), .in_avail(!fifo_empty), .in_data(fifo_dout),
            .take(fifo_pop), .release_buf(release_buf), .rd_idx(rd_idx),
            .rd_data(ch_rd[g]), .filled(ch_filled[g]), .fill_done(ch_done[g])
        );

        // R2: a conversion only begins after an enabled counter cycle
        a_r2_convert_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(adc_cs_n[g]) |-> $past(count_en));
    end

    assign rd_data    = ch_rd[rd_ch];
    assign batch_done = ch_done[0];

    // R3: the last count of a period is followed by zero
    a_r3_counter_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        count_en && (period != '0) && (cnt_q == period - 1'b1) |=> cnt_q == '0);
    // R8: channel 1 completes its batch only while channel 0's is held
    a_r8_ch1_trails_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        ch_done[1] |-> ch_filled[0]);
endmodule

// File: tb/adc_batch_collector_tb_top.sv
`timescale 1ns/1ps
module adc_batch_collector_tb_top;
    localparam int DEPTH = 4;
    localparam int N     = 8;

    logic        clk = 1'b0;
    logic        rst_n, count_en, release_buf, rd_ch;
    logic [7:0]  period;
    logic [3:0]  setup_cycles;
    logic        miso0 = 1'b0, miso1 = 1'b0;
    logic [1:0]  adc_miso, adc_cs_n, adc_sck, overrun;
    logic [2:0]  rd_idx;
    logic [15:0] rd_data;
    logic        batch_done;

    assign adc_miso = {miso1, miso0};
    always #4 clk = ~clk;

    adc_batch_collector #(.FIFO_DEPTH(DEPTH), .BATCH_N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .period(period),
        .setup_cycles(setup_cycles), .adc_miso(adc_miso), .adc_cs_n(adc_cs_n),
        .adc_sck(adc_sck), .release_buf(release_buf), .rd_ch(rd_ch),
        .rd_idx(rd_idx), .rd_data(rd_data), .batch_done(batch_done),
        .overrun(overrun)
    );

    int n_chk = 0, n_fail = 0;
    int n0 = 0, n1 = 0, cur0 = 0, cur1 = 0;
    int falls0 = 0, falls1 = 0, ndone = 0;
    bit have_prev = 0, finished = 0;
    bit ovr0 = 0, ovr1 = 0;
    logic [15:0] hist0 [512], hist1 [512];
    bit drop0 [512], drop1 [512];
    time t_cs0 = 0, t_prev = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // converter models: a new random word per select fall, next bit on each clock fall
    initial forever begin
        logic [15:0] v;
        @(negedge adc_cs_n[0]);
        v = 16'($urandom);
        miso0 = v[15];
        for (int b = 14; b >= 0; b--) begin
            @(negedge adc_sck[0]);
            miso0 = v[b];
        end
        @(posedge adc_cs_n[0]);
        hist0[n0] = v;
        n0++;
    end

    initial forever begin
        logic [15:0] v;
        @(negedge adc_cs_n[1]);
        v = 16'($urandom);
        miso1 = v[15];
        for (int b = 14; b >= 0; b--) begin
            @(negedge adc_sck[1]);
            miso1 = v[b];
        end
        @(posedge adc_cs_n[1]);
        hist1[n1] = v;
        n1++;
    end

    // timing monitors for R3, R4, R5
    initial forever begin
        time t;
        int  s;
        @(negedge adc_cs_n[0]);
        t = $time;
        s = int'(setup_cycles);
        t_cs0 = t;
        falls0++;
        if (have_prev) chk("R3 select spacing", 32'((t - t_prev) / 8), 32'(period));
        t_prev = t;
        have_prev = 1;
        @(posedge adc_sck[0]);
        chk("R5 setup to first clock", 32'(($time - t) / 8), 32'(s + 2));
    end

    initial forever begin
        @(negedge adc_cs_n[1]);
        falls1++;
        chk("R4 channel offset", 32'(($time - t_cs0) / 8), 32'd1);
    end

    initial forever begin
        bit prev;
        @(negedge clk);
        if (rst_n && batch_done) begin
            ndone++;
            if (prev) chk("R8 pulse width", 32'd2, 32'd1);
        end
        prev = batch_done;
    end

    task automatic rd(input logic ch, input int idx, output logic [15:0] d);
        @(negedge clk);
        rd_ch  = ch;
        rd_idx = 3'(idx);
        #1;
        d = rd_data;
    endtask

    // R6 R7: stored words match the sent words, in order, skipping dropped ones
    task automatic verify(input string tag);
        logic [15:0] d;
        for (int i = 0; i < N; i++) begin
            while (drop0[cur0]) cur0++;
            rd(1'b0, i, d);
            chk({tag, " ch0"}, 32'(d), 32'(hist0[cur0]));
            cur0++;
        end
        for (int i = 0; i < N; i++) begin
            while (drop1[cur1]) cur1++;
            rd(1'b1, i, d);
            chk({tag, " ch1"}, 32'(d), 32'(hist1[cur1]));
            cur1++;
        end
    endtask

    task automatic pulse_release();
        @(negedge clk);
        release_buf = 1'b1;
        @(negedge clk);
        release_buf = 1'b0;
    endtask

    initial begin
        int extras [6];
        string tags [6];
        extras = '{0, 2, 4, 6, 1, 3};
        tags   = '{"R6 R7", "R7", "R9 R11", "R9", "R10", "R9"};
        void'($urandom(32'h5EED_0A0C));
        rst_n = 1'b0; count_en = 1'b0; release_buf = 1'b0;
        rd_ch = 1'b0; rd_idx = '0; period = 8'd64;
        setup_cycles = 4'($urandom % 16);
        repeat (5) @(negedge clk);
        chk("R1 select idle", 32'(adc_cs_n), 32'h3);
        chk("R1 clock idle", 32'(adc_sck), 32'h0);
        chk("R1 done idle", 32'(batch_done), 32'h0);
        chk("R1 overrun clear", 32'(overrun), 32'h0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        chk("R2 no conversion while off", 32'(falls0 + falls1), 32'h0);
        count_en = 1'b1;

        for (int k = 0; k < 6; k++) begin
            int h0, h1, f0, f1;
            wait (ndone == k + 1);
            repeat (5) @(negedge clk);
            chk("R8 one pulse per batch", 32'(ndone), 32'(k + 1));
            verify(tags[k]);
            wait (n0 >= cur0 + extras[k] && n1 >= cur1 + extras[k]);
            @(negedge adc_cs_n[0]);
            h0 = n0 - cur0;
            h1 = n1 - cur1;
            if (h0 > DEPTH) begin
                ovr0 = 1;
                for (int i = cur0 + DEPTH; i < n0; i++) drop0[i] = 1;
            end
            if (h1 > DEPTH) begin
                ovr1 = 1;
                for (int i = cur1 + DEPTH; i < n1; i++) drop1[i] = 1;
            end
            @(negedge clk);
            chk("R10 overrun flags", 32'(overrun), 32'({ovr1, ovr0}));
            pulse_release();
            if (k == 1) begin
                // R11: release while the next batch is still filling
                wait (n0 >= cur0 + DEPTH + 3);
                @(negedge adc_cs_n[0]);
                pulse_release();
            end
            if (k == 2) begin
                // R2: pause the counter mid-run, then resume with new settings
                wait (n0 >= cur0 + 2);
                @(negedge adc_cs_n[1]);
                @(negedge clk);
                count_en = 1'b0;
                f0 = falls0;
                f1 = falls1;
                repeat (300) @(negedge clk);
                chk("R2 paused counter", 32'(falls0 + falls1), 32'(f0 + f1));
                have_prev = 0;
                period = 8'(56 + $urandom % 24);
                setup_cycles = 4'($urandom % 16);
                count_en = 1'b1;
            end
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule